// File: doc/BRIEF.md
# Prioritized Reference Clock Qualifier and Selector

This block watches several reference clock inputs, each sampled in one fast system clock domain. Every input passes through a synchronizer. Its rising edges are counted over a window of 2^WIN_LOG2 system cycles, and all inputs share the same window. At the end of each window the count is compared with a programmed expected count and tolerance.

An input earns its valid flag after a run of good windows. A single bad window or a silent window removes the flag. A priority value per input ranks the qualified inputs. A selector picks the best one without outside help, in either revertive or nonrevertive mode. The selector raises a one-cycle fail pulse when the input it is using loses qualification.

The rising edges of the chosen input then feed an integer divider. The divider emits a one-cycle tick for every Nth edge, and this tick is the rate handed on to the downstream loop.

Top module: `refsel_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `ref_valid`, `sel_ok`, `sel_fail` and `div_tick` are all 0.
- R2: A window lasts 2^WIN_LOG2 cycles, and all inputs share the same window. A window is in tolerance for an input when its synchronized rising-edge count is nonzero and differs from that input's `exp_cnt` field by at most `tol`.
- R3: The valid flag of an input rises at the end of the third consecutive in-tolerance window. It falls at the end of any window that is out of tolerance or has no edges. It changes only at window ends.
- R4: An input whose priority field is 0 is never selected, even while it is valid.
- R5: The candidate is the valid input with the largest nonzero priority value. When priorities tie, the lowest input index wins.
- R6: With `revertive`=1, the selection moves to a better candidate on the cycle after that candidate becomes valid.
- R7: With `revertive`=0, the selection stays on the current input for as long as that input is valid and enabled.
- R8: `sel_fail` is 1 for exactly one cycle, starting in the cycle in which the selected input's valid flag reads 0 (or its priority reads 0). On the next cycle the selection moves to the best candidate, or `sel_ok` drops if there is none.
- R9: `div_tick` pulses one cycle after every `div_ratio`-th synchronized rising edge of the selected input. A ratio of 0 acts as 1. The edge count restarts whenever the selection changes or `sel_ok` is 0.
- R10: `sel_ok` is 0 whenever no input is both valid and enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | NUM_IN | Raw reference clock inputs |
| exp_cnt | input | NUM_IN*CNT_W | Expected edges per window; input i occupies bits [i*CNT_W +: CNT_W] |
| tol | input | CNT_W | Allowed absolute deviation from the expected count |
| prio | input | NUM_IN*PRIO_W | Priority of input i at [i*PRIO_W +: PRIO_W]; larger wins, 0 disables |
| revertive | input | 1 | 1 = revertive switching, 0 = nonrevertive |
| div_ratio | input | DIV_W | Divide ratio applied to the selected input's edges |
| ref_valid | output | NUM_IN | Per-input qualification flags |
| sel_idx | output | IDX_W | Index of the selected input |
| sel_ok | output | 1 | A selection is in force |
| sel_fail | output | 1 | One-cycle pulse when the selected input is lost |
| div_tick | output | 1 | One-cycle pulse per divided period |

## Verification
The hardest case to reach is revertive versus nonrevertive behaviour. It needs a high-priority input to be lost, then requalified over three full windows while a lower-priority input carries the selection. The bench gets there by stopping and restarting the toggling of individual inputs. It does this once in each mode, and then pushes another input off frequency so that qualification fails on a window that still holds edges. A behavioural model computes the counts, flags, selection, fail pulse and divider ticks every cycle. It compares them with the outputs, so the exact cycle of each transition is checked.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
   function automatic int idx_bits(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/refsel_mon.sv
module refsel_mon #(
   parameter int CNT_W    = 7,
   parameter int RUN_GOOD = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_raw,
   input  logic             win_end,
   input  logic [CNT_W-1:0] exp_cnt,
   input  logic [CNT_W-1:0] tol,
   output logic             rise,
   output logic             valid
);
   localparam int RUN_W = $clog2(RUN_GOOD + 1);
   localparam logic [CNT_W-1:0] CMAX = '1;

   if (RUN_GOOD < 1) begin : g_bad_run
      $error("RUN_GOOD must be at least 1");
   end

   logic [2:0]       sh;
   logic [CNT_W-1:0] cnt, total, diff;
   logic [RUN_W-1:0] run;
   logic             in_tol;

   assign rise   = sh[1] & ~sh[2];
   assign total  = (rise && cnt != CMAX) ? cnt + 1'b1 : cnt;
   assign diff   = (total >= exp_cnt) ? total - exp_cnt : exp_cnt - total;
   assign in_tol = (total != '0) && (diff <= tol);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh    <= '0;
         cnt   <= '0;
         run   <= '0;
         valid <= 1'b0;
      end else begin
         sh <= {sh[1:0], ref_raw};
         if (win_end) begin
            cnt <= '0;
            if (in_tol) begin
               if (run != RUN_W'(RUN_GOOD)) run <= run + 1'b1;
               valid <= (run >= RUN_W'(RUN_GOOD - 1));
            end else begin
               run   <= '0;
               valid <= 1'b0;
            end
         end else begin
            cnt <= total;
         end
      end
   end

   // R3
   valid_rise_at_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid) |-> $past(win_end));
   // R3
   valid_fall_at_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(valid) |-> $past(win_end));
endmodule

// File: rtl/refsel_pick.sv
module refsel_pick #(
   parameter int NUM_IN = 5,
   parameter int PRIO_W = 4,
   parameter int IDX_W  = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_IN-1:0]        valid,
   input  logic [NUM_IN*PRIO_W-1:0] prio,
   input  logic                     revertive,
   output logic [IDX_W-1:0]         sel_idx,
   output logic                     sel_ok,
   output logic                     sel_fail
);
   logic [NUM_IN-1:0] elig;
   logic [IDX_W-1:0]  best;
   logic [PRIO_W-1:0] best_p;
   logic              found, cur_elig;

   always_comb begin
      found    = 1'b0;
      best     = '0;
      best_p   = '0;
      cur_elig = 1'b0;
      for (int i = 0; i < NUM_IN; i++) begin
         elig[i] = valid[i] && (prio[i*PRIO_W +: PRIO_W] != '0);
         if (elig[i] && (!found || prio[i*PRIO_W +: PRIO_W] > best_p)) begin
            found  = 1'b1;
            best   = IDX_W'(i);
            best_p = prio[i*PRIO_W +: PRIO_W];
         end
         if (sel_idx == IDX_W'(i)) cur_elig = elig[i];
      end
   end

   assign sel_fail = sel_ok & ~cur_elig;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_idx <= '0;
         sel_ok  <= 1'b0;
      end else if (!(sel_ok && cur_elig)) begin
         sel_ok <= found;
         if (found) sel_idx <= best;
      end else if (revertive && best != sel_idx) begin
         sel_idx <= best;
      end
   end

   // R8
   fail_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_fail |=> !sel_fail);
   // R8
   fail_moves_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_fail |=> (!sel_ok || sel_idx != $past(sel_idx)));
   // R7
   nonrevert_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_ok && !sel_fail && !revertive) |=> (sel_ok && $stable(sel_idx)));
endmodule

// File: rtl/refsel_div.sv
module refsel_div #(
   parameter int NUM_IN = 5,
   parameter int IDX_W  = 3,
   parameter int DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_IN-1:0] rise,
   input  logic [IDX_W-1:0]  sel_idx,
   input  logic              sel_ok,
   input  logic [DIV_W-1:0]  ratio,
   output logic              tick
);
   logic [DIV_W-1:0] dcnt, eff;
   logic [IDX_W-1:0] prev_idx;
   logic             sel_rise;

   always_comb begin
      sel_rise = 1'b0;
      for (int i = 0; i < NUM_IN; i++)
         if (sel_idx == IDX_W'(i)) sel_rise = rise[i];
   end

   assign eff = (ratio == '0) ? DIV_W'(1) : ratio;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dcnt     <= '0;
         tick     <= 1'b0;
         prev_idx <= '0;
      end else begin
         prev_idx <= sel_idx;
         if (!sel_ok || sel_idx != prev_idx) begin
            dcnt <= '0;
            tick <= 1'b0;
         end else if (sel_rise) begin
            if (dcnt >= eff - 1'b1) begin
               dcnt <= '0;
               tick <= 1'b1;
            end else begin
               dcnt <= dcnt + 1'b1;
               tick <= 1'b0;
            end
         end else begin
            tick <= 1'b0;
         end
      end
   end

   // R9
   tick_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
   // R9
   tick_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> $past(sel_ok));
endmodule

// File: rtl/refsel_top.sv
module refsel_top
   import refsel_pkg::*;
#(
   parameter int NUM_IN   = 5,
   parameter int WIN_LOG2 = 6,
   parameter int PRIO_W   = 4,
   parameter int DIV_W    = 8,
   parameter int RUN_GOOD = 3,
   localparam int CNT_W   = WIN_LOG2 + 1,
   localparam int IDX_W   = idx_bits(NUM_IN)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_IN-1:0]        ref_in,
   input  logic [NUM_IN*CNT_W-1:0]  exp_cnt,
   input  logic [CNT_W-1:0]         tol,
   input  logic [NUM_IN*PRIO_W-1:0] prio,
   input  logic                     revertive,
   input  logic [DIV_W-1:0]         div_ratio,
   output logic [NUM_IN-1:0]        ref_valid,
   output logic [IDX_W-1:0]         sel_idx,
   output logic                     sel_ok,
   output logic                     sel_fail,
   output logic                     div_tick
);
   if (NUM_IN < 1 || WIN_LOG2 < 2 || PRIO_W < 1 || DIV_W < 1) begin : g_bad_cfg
      $error("refsel_top: illegal parameter set");
   end

   logic [WIN_LOG2-1:0] wcnt;
   logic                win_end;
   logic [NUM_IN-1:0]   rise;

   assign win_end = &wcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wcnt <= '0;
      else        wcnt <= wcnt + 1'b1;
   end

   for (genvar g = 0; g < NUM_IN; g++) begin : g_mon
      refsel_mon #(.CNT_W(CNT_W), .RUN_GOOD(RUN_GOOD)) u_mon (
         .clk     (clk),
         .rst_n   (rst_n),
         .ref_raw (ref_in[g]),
         .win_end (win_end),
         .exp_cnt (exp_cnt[g*CNT_W +: CNT_W]),
         .tol     (tol),
         .rise    (rise[g]),
         .valid   (ref_valid[g])
      );
   end

   refsel_pick #(.NUM_IN(NUM_IN), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid     (ref_valid),
      .prio      (prio),
      .revertive (revertive),
      .sel_idx   (sel_idx),
      .sel_ok    (sel_ok),
      .sel_fail  (sel_fail)
   );

   refsel_div #(.NUM_IN(NUM_IN), .IDX_W(IDX_W), .DIV_W(DIV_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .rise    (rise),
      .sel_idx (sel_idx),
      .sel_ok  (sel_ok),
      .ratio   (div_ratio),
      .tick    (div_tick)
   );
endmodule

// File: tb/refsel_top_bench.sv
module refsel_top_bench;
   localparam int NI  = 5;
   localparam int WL  = 6;
   localparam int WIN = 1 << WL;
   localparam int CW  = WL + 1;
   localparam int PW  = 4;
   localparam int DW  = 8;
   localparam int IW  = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NI-1:0]     ref_in = '0;
   logic [NI*CW-1:0]  exp_cnt = '0;
   logic [CW-1:0]     tol = '0;
   logic [NI*PW-1:0]  prio = '0;
   logic              revertive = 1'b0;
   logic [DW-1:0]     div_ratio = '0;
   logic [NI-1:0]     ref_valid;
   logic [IW-1:0]     sel_idx;
   logic              sel_ok, sel_fail, div_tick;

   int checks = 0;
   int failures = 0;
   int half[NI];
   int phase[NI];
   int fail_seen = 0;
   int tick_seen = 0;

   // behavioural model state
   int m_hist[NI][3];
   int m_cnt[NI], m_run[NI];
   bit m_vld[NI];
   int m_wc, m_cur, m_prev, m_dc;
   bit m_ok, m_tick;

   always #4 clk = ~clk;

   refsel_top u_refsel_top (
      .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .exp_cnt(exp_cnt), .tol(tol),
      .prio(prio), .revertive(revertive), .div_ratio(div_ratio),
      .ref_valid(ref_valid), .sel_idx(sel_idx), .sel_ok(sel_ok),
      .sel_fail(sel_fail), .div_tick(div_tick)
   );

   function automatic int prio_of(int i);
      return int'(prio[i*PW +: PW]);
   endfunction

   function automatic int exp_of(int i);
      return int'(exp_cnt[i*CW +: CW]);
   endfunction

   function automatic bit elig_m(int i);
      return m_vld[i] && prio_of(i) != 0;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
      end
   endtask

   // reference clock stimulus, driven away from the sampling edge
   always @(negedge clk) begin
      for (int i = 0; i < NI; i++) begin
         if (half[i] > 0) begin
            phase[i]++;
            if (phase[i] >= half[i]) begin
               phase[i] = 0;
               ref_in[i] = ~ref_in[i];
            end
         end
      end
   end

   // reference model, advanced on every sampling edge
   always @(posedge clk) begin
      bit r[NI];
      bit we, found, cur_el;
      int best, bp, tot, dif, eff;
      if (!rst_n) begin
         for (int i = 0; i < NI; i++) begin
            for (int k = 0; k < 3; k++) m_hist[i][k] = 0;
            m_cnt[i] = 0; m_run[i] = 0; m_vld[i] = 0;
         end
         m_wc = 0; m_cur = 0; m_prev = 0; m_dc = 0; m_ok = 0; m_tick = 0;
      end else begin
         we = (m_wc == WIN - 1);
         for (int i = 0; i < NI; i++) r[i] = (m_hist[i][1] == 1) && (m_hist[i][2] == 0);
         // divider, from present selection
         eff = (div_ratio == 0) ? 1 : int'(div_ratio);
         if (!m_ok || m_cur != m_prev) begin
            m_dc = 0; m_tick = 0;
         end else if (r[m_cur]) begin
            if (m_dc >= eff - 1) begin m_dc = 0; m_tick = 1; end
            else begin m_dc++; m_tick = 0; end
         end else m_tick = 0;
         m_prev = m_cur;
         // selection, from present flags
         found = 0; best = 0; bp = 0;
         for (int i = 0; i < NI; i++)
            if (elig_m(i) && (!found || prio_of(i) > bp)) begin
               found = 1; best = i; bp = prio_of(i);
            end
         cur_el = m_ok && elig_m(m_cur);
         if (!cur_el) begin
            m_ok = found;
            if (found) m_cur = best;
         end else if (revertive && best != m_cur) m_cur = best;
         // qualification
         for (int i = 0; i < NI; i++) begin
            tot = m_cnt[i] + (r[i] ? 1 : 0);
            if (tot > (1 << CW) - 1) tot = (1 << CW) - 1;
            if (we) begin
               dif = (tot >= exp_of(i)) ? tot - exp_of(i) : exp_of(i) - tot;
               if (tot != 0 && dif <= int'(tol)) begin
                  m_vld[i] = (m_run[i] >= 2);
                  if (m_run[i] < 3) m_run[i]++;
               end else begin
                  m_run[i] = 0; m_vld[i] = 0;
               end
               m_cnt[i] = 0;
            end else m_cnt[i] = tot;
         end
         for (int i = 0; i < NI; i++) begin
            m_hist[i][2] = m_hist[i][1];
            m_hist[i][1] = m_hist[i][0];
            m_hist[i][0] = ref_in[i] ? 1 : 0;
         end
         m_wc = (m_wc + 1) % WIN;
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         logic [NI-1:0] ev;
         bit efail;
         for (int i = 0; i < NI; i++) ev[i] = m_vld[i];
         efail = m_ok && !elig_m(m_cur);
         check(ref_valid == ev, "R2/R3 valid flags", int'(ref_valid), int'(ev));
         check(sel_ok == m_ok, "R10 sel_ok", int'(sel_ok), int'(m_ok));
         check(!m_ok || int'(sel_idx) == m_cur, "R5 sel_idx", int'(sel_idx), m_cur);
         check(sel_fail == efail, "R8 sel_fail", int'(sel_fail), int'(efail));
         check(div_tick == m_tick, "R9 div_tick", int'(div_tick), int'(m_tick));
         if (sel_fail) fail_seen++;
         if (div_tick) tick_seen++;
      end
   end

   task automatic wait_win(input int n);
      repeat (n * WIN) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < NI; i++) begin half[i] = 0; phase[i] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      check(ref_valid == '0, "R1 valid in reset", int'(ref_valid), 0);
      check(!sel_ok && !sel_fail && !div_tick, "R1 outputs in reset",
            int'({sel_ok, sel_fail, div_tick}), 0);
      half[0] = 2; half[1] = 4; half[2] = 4; half[3] = 2; half[4] = 8;
      exp_cnt[0*CW +: CW] = 16; exp_cnt[1*CW +: CW] = 8; exp_cnt[2*CW +: CW] = 8;
      exp_cnt[3*CW +: CW] = 16; exp_cnt[4*CW +: CW] = 6;
      tol = 1;
      prio[0*PW +: PW] = 3; prio[1*PW +: PW] = 5; prio[2*PW +: PW] = 5;
      prio[3*PW +: PW] = 0; prio[4*PW +: PW] = 1;
      revertive = 1'b1;
      div_ratio = 0;
      rst_n = 1'b1;
      @(negedge clk);
      check(!sel_ok && ref_valid == '0, "R1 first cycle after reset", int'(sel_ok), 0);
      wait_win(5);
      // R2: input 4 sees 4 edges against 6 +/- 1
      check(ref_valid == 5'b01111, "R2 tolerance window", int'(ref_valid), 15);
      // R5: tie between 1 and 2 goes to lower index
      check(sel_ok && sel_idx == 1, "R5 priority tie", int'(sel_idx), 1);
      exp_cnt[4*CW +: CW] = 4;
      div_ratio = 3;
      wait_win(4);
      check(ref_valid[4] == 1'b1, "R3 requalified after three windows", int'(ref_valid[4]), 1);
      check(tick_seen > 0, "R9 divider produces ticks", tick_seen, 1);
      // lose input 1 in revertive mode
      fail_seen = 0;
      half[1] = 0;
      wait_win(2);
      check(sel_idx == 2, "R8 switched after loss", int'(sel_idx), 2);
      check(fail_seen == 1, "R8 one fail pulse", fail_seen, 1);
      half[1] = 4;
      wait_win(5);
      check(sel_idx == 1, "R6 revert to higher priority", int'(sel_idx), 1);
      // nonrevertive
      revertive = 1'b0;
      half[1] = 0;
      wait_win(2);
      check(sel_idx == 2, "R7 moved off lost input", int'(sel_idx), 2);
      half[1] = 4;
      wait_win(5);
      check(ref_valid[1] && sel_idx == 2, "R7 no revert", int'(sel_idx), 2);
      // frequency error on input 2: 16 edges against 8 +/- 1
      half[2] = 2;
      fail_seen = 0;
      wait_win(2);
      check(!ref_valid[2] && sel_idx == 1, "R3 off-frequency drop", int'(sel_idx), 1);
      check(fail_seen == 1, "R8 fail on frequency error", fail_seen, 1);
      // only the disabled input stays alive
      half[0] = 0; half[1] = 0; half[2] = 0; half[4] = 0;
      wait_win(3);
      check(ref_valid == 5'b01000, "R4 disabled input still valid", int'(ref_valid), 8);
      check(!sel_ok, "R4 R10 disabled input never selected", int'(sel_ok), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule